// File: doc/BRIEF.md
# Compacting Age-Ordered Issue Column

This block is a single column of a banked instruction issue window. It holds up to `DEPTH` waiting instructions in a stack ordered by age. The oldest entry sits at slot 0, and each new arrival is placed directly above the youngest entry already held. Every entry tracks one source operand tag. That tag is matched only against the result tag broadcast by the neighbouring producer column. An instruction that was split in two can be parked here as a dormant second half. It stays invisible to selection until a short second-part tag, broadcast when its first half issues, wakes it.

In each cycle the column offers at most one instruction on its issue port: the oldest entry that is awake, has its operand, and has not yet issued. A returning cache miss can claim the column's write port for a cycle, and that silences issue. Issued entries remain in place so they can be replayed, until a completion names their slot. The slot is then squeezed out: the entries above it slide down one position, and a dispatch in the same cycle lands in the freed top position. A flush discards all entries above a kept count of the oldest.

Top module: `issue_column`

## Requirements
- R1: After reset the column is empty: occupancy is 0, full is low and no issue is offered.
- R2: An accepted dispatch is placed at slot index equal to the current occupancy and raises occupancy by one. An entry dispatched with its operand marked ready can issue in the following cycle.
- R3: The issue port offers the lowest-index (oldest) entry that is valid, awake, operand-ready and not yet issued, at most one per cycle, with its slot index and payload. An issued entry is never offered again and still counts toward occupancy.
- R4: A waiting entry whose source tag equals the producer tag broadcast while the wake valid input is high becomes ready and can issue from the next cycle. A non-matching broadcast leaves it waiting. A dispatch whose tag matches a broadcast in the same cycle enters as ready.
- R5: An entry dispatched with the second-part flag is not offered until a second-part wakeup carrying its second-part tag arrives. It can issue from the cycle after that wakeup. A wakeup with a different second-part tag has no effect.
- R6: While the cache-miss request is high, no issue is offered, and the entry that would have issued stays eligible for a later cycle.
- R7: Freeing slot k (k below occupancy) removes that entry. Slots below k keep their contents, each slot at or above k takes the content of the slot above it, and occupancy drops by one. A free naming a slot at or above occupancy is ignored.
- R8: A dispatch in the same cycle as a valid free is placed at slot occupancy minus one, above all entries that survive the free.
- R9: Full is high exactly when occupancy equals `DEPTH`. A dispatch offered while full is dropped and leaves occupancy unchanged.
- R10: A flush with keep count K removes every slot at index K or above, so occupancy becomes the smaller of K and the previous occupancy. A dispatch or free in the same cycle as a flush is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch request |
| disp_pay | input | PAY_W | Instruction payload carried through to issue |
| disp_tag | input | TAG_W | Source tag the entry waits on |
| disp_rdy | input | 1 | Operand already available (or none needed) |
| disp_part2 | input | 1 | Entry is a dormant second half |
| disp_p2tag | input | P2_W | Second-part tag of a dormant entry |
| wk_valid | input | 1 | Producer-column tag broadcast valid |
| wk_tag | input | TAG_W | Producer-column result tag |
| p2_valid | input | 1 | Second-part wakeup valid |
| p2_tag | input | P2_W | Second-part wakeup tag |
| miss_req | input | 1 | Returning cache miss claims the write port; blocks issue |
| free_valid | input | 1 | Completion confirmed for a slot |
| free_idx | input | IDX_W | Slot index to free |
| flush_valid | input | 1 | Flush younger entries |
| flush_keep | input | CNT_W | Number of oldest entries kept by a flush |
| iss_valid | output | 1 | An entry is issued this cycle |
| iss_idx | output | IDX_W | Slot index of the issued entry |
| iss_pay | output | PAY_W | Payload of the issued entry |
| occupancy | output | CNT_W | Number of valid entries |
| full | output | 1 | Column holds DEPTH entries |

## Verification
A wrong shift during compaction shows up at the issue port as a payload that appears at an unexpected slot index, or as a payload that is missing or duplicated. The bench therefore drains the column after each free or flush and compares the whole issue order. A lost or spurious ready, awake or issued flag appears within one cycle as an issue that comes too early, too late or twice. Occupancy and full are sampled every cycle around insertions, frees and flushes, so a counter that drifts is seen on the next cycle.

// File: rtl/ic_pkg.sv
package ic_pkg;

    localparam int IC_DEPTH = 12;
    localparam int IC_TAG_W = 5;
    localparam int IC_P2_W  = 2;
    localparam int IC_PAY_W = 16;

    // Per-entry scheduling state
    typedef struct packed {
        logic vld;   // slot holds an instruction
        logic done;  // already issued, waiting for completion
        logic rdy;   // source operand available
        logic dorm;  // second half still asleep
    } ic_flags_t;

    localparam ic_flags_t IC_EMPTY = '0;

    function automatic logic ic_eligible(ic_flags_t f);
        return f.vld & ~f.done & f.rdy & ~f.dorm;
    endfunction

endpackage

// File: rtl/ic_wake.sv
module ic_wake
    import ic_pkg::*;
#(
    parameter int DEPTH = IC_DEPTH,
    parameter int TAG_W = IC_TAG_W,
    parameter int P2_W  = IC_P2_W
) (
    input  ic_flags_t [DEPTH-1:0]            flags,
    input  logic      [DEPTH-1:0][TAG_W-1:0] tags,
    input  logic      [DEPTH-1:0][P2_W-1:0]  p2tags,
    input  logic                             wk_valid,
    input  logic      [TAG_W-1:0]            wk_tag,
    input  logic                             p2_valid,
    input  logic      [P2_W-1:0]             p2_tag,
    input  logic      [TAG_W-1:0]            disp_tag,
    output logic      [DEPTH-1:0]            rdy_hit,
    output logic      [DEPTH-1:0]            p2_hit,
    output logic                             disp_wake
);

    // One comparator per entry for each wakeup port
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign rdy_hit[g] = flags[g].vld & ~flags[g].done & ~flags[g].rdy
                          & wk_valid & (tags[g] == wk_tag);
        assign p2_hit[g]  = flags[g].vld & flags[g].dorm
                          & p2_valid & (p2tags[g] == p2_tag);
    end

    assign disp_wake = wk_valid & (disp_tag == wk_tag);

endmodule

// File: rtl/ic_select.sv
module ic_select #(
    parameter int DEPTH = 12,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] elig,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    // Fixed priority: lowest slot (oldest) wins
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (elig[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/ic_store.sv
module ic_store
    import ic_pkg::*;
#(
    parameter int DEPTH = IC_DEPTH,
    parameter int TAG_W = IC_TAG_W,
    parameter int P2_W  = IC_P2_W,
    parameter int PAY_W = IC_PAY_W,
    parameter int IDX_W = $clog2(DEPTH),
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             disp_ok,
    input  logic                             disp_rdy,
    input  logic                             disp_part2,
    input  logic      [PAY_W-1:0]            disp_pay,
    input  logic      [TAG_W-1:0]            disp_tag,
    input  logic      [P2_W-1:0]             disp_p2tag,
    input  logic      [DEPTH-1:0]            rdy_hit,
    input  logic      [DEPTH-1:0]            p2_hit,
    input  logic                             iss_fire,
    input  logic      [IDX_W-1:0]            iss_idx,
    input  logic                             free_valid,
    input  logic      [IDX_W-1:0]            free_idx,
    input  logic                             flush_valid,
    input  logic      [CNT_W-1:0]            flush_keep,
    output ic_flags_t [DEPTH-1:0]            flags,
    output logic      [DEPTH-1:0][TAG_W-1:0] tags,
    output logic      [DEPTH-1:0][P2_W-1:0]  p2tags,
    output logic      [DEPTH-1:0][PAY_W-1:0] pays,
    output logic      [CNT_W-1:0]            cnt
);

    ic_flags_t [DEPTH-1:0]            flags_q, flags_n;
    logic      [DEPTH-1:0][TAG_W-1:0] tags_q, tags_n;
    logic      [DEPTH-1:0][P2_W-1:0]  p2_q, p2_n;
    logic      [DEPTH-1:0][PAY_W-1:0] pay_q, pay_n;
    logic      [CNT_W-1:0]            cnt_q, cnt_n, cnt_mid;

    // Updated state with one padding slot on top, used as the shift source
    ic_flags_t [DEPTH:0]              upd;
    logic      [DEPTH:0][TAG_W-1:0]   tag_x;
    logic      [DEPTH:0][P2_W-1:0]    p2_x;
    logic      [DEPTH:0][PAY_W-1:0]   pay_x;

    logic free_ok;
    logic [DEPTH-1:0] vld_vec;

    assign free_ok = free_valid & ~flush_valid & (CNT_W'(free_idx) < cnt_q);
    assign cnt_mid = cnt_q - CNT_W'(free_ok);

    // Stage 1: apply wakeups and the issue mark in place
    always_comb begin
        upd[DEPTH]   = IC_EMPTY;
        tag_x[DEPTH] = '0;
        p2_x[DEPTH]  = '0;
        pay_x[DEPTH] = '0;
        for (int i = 0; i < DEPTH; i++) begin
            upd[i]   = flags_q[i];
            tag_x[i] = tags_q[i];
            p2_x[i]  = p2_q[i];
            pay_x[i] = pay_q[i];
            if (rdy_hit[i]) upd[i].rdy = 1'b1;
            if (p2_hit[i])  upd[i].dorm = 1'b0;
            if (iss_fire && iss_idx == IDX_W'(i)) upd[i].done = 1'b1;
        end
    end

    // Stage 2: compaction, insertion, flush
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            if (free_ok && CNT_W'(i) >= CNT_W'(free_idx)) begin
                flags_n[i] = upd[i+1];
                tags_n[i]  = tag_x[i+1];
                p2_n[i]    = p2_x[i+1];
                pay_n[i]   = pay_x[i+1];
            end else begin
                flags_n[i] = upd[i];
                tags_n[i]  = tag_x[i];
                p2_n[i]    = p2_x[i];
                pay_n[i]   = pay_x[i];
            end
            if (disp_ok && CNT_W'(i) == cnt_mid) begin
                flags_n[i] = '{vld: 1'b1, done: 1'b0, rdy: disp_rdy, dorm: disp_part2};
                tags_n[i]  = disp_tag;
                p2_n[i]    = disp_p2tag;
                pay_n[i]   = disp_pay;
            end
            if (flush_valid && CNT_W'(i) >= flush_keep) begin
                flags_n[i] = IC_EMPTY;
            end
        end
        cnt_n = cnt_mid + CNT_W'(disp_ok);
        if (flush_valid && flush_keep < cnt_q) begin
            cnt_n = flush_keep;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            tags_q  <= '0;
            p2_q    <= '0;
            pay_q   <= '0;
            cnt_q   <= '0;
        end else begin
            flags_q <= flags_n;
            tags_q  <= tags_n;
            p2_q    <= p2_n;
            pay_q   <= pay_n;
            cnt_q   <= cnt_n;
        end
    end

    assign flags  = flags_q;
    assign tags   = tags_q;
    assign p2tags = p2_q;
    assign pays   = pay_q;
    assign cnt    = cnt_q;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) vld_vec[i] = flags_q[i].vld;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(DEPTH)); // R9

    AST_NO_HOLES: assert property (@(posedge clk) disable iff (rst)
        ((vld_vec + DEPTH'(1)) & vld_vec) == '0); // R7

    AST_COUNT_MATCH: assert property (@(posedge clk) disable iff (rst)
        CNT_W'($countones(vld_vec)) == cnt_q); // R2

    AST_FLUSH_BOUND: assert property (@(posedge clk) disable iff (rst)
        flush_valid |=> cnt_q <= $past(flush_keep)); // R10

    AST_ISSUED_KEPT: assert property (@(posedge clk) disable iff (rst)
        (iss_fire && !free_valid && !flush_valid && !disp_ok) |=> cnt_q == $past(cnt_q)); // R3

endmodule

// File: rtl/issue_column.sv
module issue_column
    import ic_pkg::*;
#(
    parameter int DEPTH = IC_DEPTH,
    parameter int TAG_W = IC_TAG_W,
    parameter int P2_W  = IC_P2_W,
    parameter int PAY_W = IC_PAY_W,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             disp_valid,
    input  logic [PAY_W-1:0] disp_pay,
    input  logic [TAG_W-1:0] disp_tag,
    input  logic             disp_rdy,
    input  logic             disp_part2,
    input  logic [P2_W-1:0]  disp_p2tag,
    input  logic             wk_valid,
    input  logic [TAG_W-1:0] wk_tag,
    input  logic             p2_valid,
    input  logic [P2_W-1:0]  p2_tag,
    input  logic             miss_req,
    input  logic             free_valid,
    input  logic [IDX_W-1:0] free_idx,
    input  logic             flush_valid,
    input  logic [CNT_W-1:0] flush_keep,
    output logic             iss_valid,
    output logic [IDX_W-1:0] iss_idx,
    output logic [PAY_W-1:0] iss_pay,
    output logic [CNT_W-1:0] occupancy,
    output logic             full
);

    ic_flags_t [DEPTH-1:0]            flags;
    logic      [DEPTH-1:0][TAG_W-1:0] tags;
    logic      [DEPTH-1:0][P2_W-1:0]  p2tags;
    logic      [DEPTH-1:0][PAY_W-1:0] pays;
    logic      [DEPTH-1:0]            rdy_hit, p2_hit, elig;
    logic      [CNT_W-1:0]            cnt;
    logic                             disp_wake, disp_ok, found;
    logic      [IDX_W-1:0]            sel_idx;

    assign full    = (cnt == CNT_W'(DEPTH));
    assign disp_ok = disp_valid & ~full & ~flush_valid;

    ic_wake #(.DEPTH(DEPTH), .TAG_W(TAG_W), .P2_W(P2_W)) u_wake (
        .flags     (flags),
        .tags      (tags),
        .p2tags    (p2tags),
        .wk_valid  (wk_valid),
        .wk_tag    (wk_tag),
        .p2_valid  (p2_valid),
        .p2_tag    (p2_tag),
        .disp_tag  (disp_tag),
        .rdy_hit   (rdy_hit),
        .p2_hit    (p2_hit),
        .disp_wake (disp_wake)
    );

    for (genvar g = 0; g < DEPTH; g++) begin : g_elig
        assign elig[g] = ic_eligible(flags[g]);
    end

    ic_select #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_sel (
        .elig  (elig),
        .found (found),
        .idx   (sel_idx)
    );

    assign iss_valid = found & ~miss_req;
    assign iss_idx   = sel_idx;
    assign iss_pay   = pays[sel_idx];
    assign occupancy = cnt;

    ic_store #(
        .DEPTH(DEPTH), .TAG_W(TAG_W), .P2_W(P2_W), .PAY_W(PAY_W),
        .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_store (
        .clk         (clk),
        .rst         (rst),
        .disp_ok     (disp_ok),
        .disp_rdy    (disp_rdy | disp_wake),
        .disp_part2  (disp_part2),
        .disp_pay    (disp_pay),
        .disp_tag    (disp_tag),
        .disp_p2tag  (disp_p2tag),
        .rdy_hit     (rdy_hit),
        .p2_hit      (p2_hit),
        .iss_fire    (iss_valid),
        .iss_idx     (sel_idx),
        .free_valid  (free_valid),
        .free_idx    (free_idx),
        .flush_valid (flush_valid),
        .flush_keep  (flush_keep),
        .flags       (flags),
        .tags        (tags),
        .p2tags      (p2tags),
        .pays        (pays),
        .cnt         (cnt)
    );

    AST_MISS_MUTES: assert property (@(posedge clk) disable iff (rst)
        miss_req |-> !iss_valid); // R6

    AST_PICK_ELIGIBLE: assert property (@(posedge clk) disable iff (rst)
        iss_valid |-> (flags[iss_idx].vld && !flags[iss_idx].done
                       && flags[iss_idx].rdy && !flags[iss_idx].dorm)); // R3

    AST_PICK_OLDEST: assert property (@(posedge clk) disable iff (rst)
        iss_valid |-> (elig & ((DEPTH'(1) << iss_idx) - DEPTH'(1))) == '0); // R3

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (full && !free_valid && !flush_valid) |=> full); // R9

endmodule

// File: tb/test_issue_column.sv
module test_issue_column;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        disp_valid, disp_rdy, disp_part2;
    logic [15:0] disp_pay;
    logic [4:0]  disp_tag;
    logic [1:0]  disp_p2tag;
    logic        wk_valid;
    logic [4:0]  wk_tag;
    logic        p2_valid;
    logic [1:0]  p2_tag;
    logic        miss_req, free_valid, flush_valid;
    logic [3:0]  free_idx;
    logic [3:0]  flush_keep;
    logic        iss_valid, full;
    logic [3:0]  iss_idx;
    logic [15:0] iss_pay;
    logic [3:0]  occupancy;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    issue_column i_issue_column (
        .clk(clk), .rst(rst),
        .disp_valid(disp_valid), .disp_pay(disp_pay), .disp_tag(disp_tag),
        .disp_rdy(disp_rdy), .disp_part2(disp_part2), .disp_p2tag(disp_p2tag),
        .wk_valid(wk_valid), .wk_tag(wk_tag), .p2_valid(p2_valid), .p2_tag(p2_tag),
        .miss_req(miss_req), .free_valid(free_valid), .free_idx(free_idx),
        .flush_valid(flush_valid), .flush_keep(flush_keep),
        .iss_valid(iss_valid), .iss_idx(iss_idx), .iss_pay(iss_pay),
        .occupancy(occupancy), .full(full)
    );

    typedef struct packed {
        logic        dv;
        logic [15:0] dpay;
        logic        drdy;
        logic [4:0]  dtag;
        logic        wv;
        logic [4:0]  wtag;
        logic        ev;
        logic [3:0]  eidx;
        logic [15:0] epay;
        logic [3:0]  ecnt;
    } vec_t;

    // One row per cycle: dispatch, broadcast, expected issue and occupancy
    localparam int NV = 8;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 16'h00A1, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 4'd0, 16'h0000, 4'd0},
        '{1'b1, 16'h00A2, 1'b0, 5'd3, 1'b0, 5'd0, 1'b1, 4'd0, 16'h00A1, 4'd1},
        '{1'b0, 16'h0000, 1'b0, 5'd0, 1'b1, 5'd7, 1'b0, 4'd0, 16'h0000, 4'd2},
        '{1'b0, 16'h0000, 1'b0, 5'd0, 1'b1, 5'd3, 1'b0, 4'd0, 16'h0000, 4'd2},
        '{1'b1, 16'h00A3, 1'b1, 5'd0, 1'b0, 5'd0, 1'b1, 4'd1, 16'h00A2, 4'd2},
        '{1'b1, 16'h00A4, 1'b0, 5'd9, 1'b1, 5'd9, 1'b1, 4'd2, 16'h00A3, 4'd3},
        '{1'b0, 16'h0000, 1'b0, 5'd0, 1'b0, 5'd0, 1'b1, 4'd3, 16'h00A4, 4'd4},
        '{1'b0, 16'h0000, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 4'd0, 16'h0000, 4'd4}
    };

    task automatic clr();
        disp_valid = 0; disp_pay = '0; disp_tag = '0; disp_rdy = 0;
        disp_part2 = 0; disp_p2tag = '0; wk_valid = 0; wk_tag = '0;
        p2_valid = 0; p2_tag = '0; miss_req = 0; free_valid = 0;
        free_idx = '0; flush_valid = 0; flush_keep = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        clr();
    endtask

    task automatic do_reset();
        clr();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic disp(input logic [15:0] p, input logic r, input logic [4:0] t);
        disp_valid = 1; disp_pay = p; disp_rdy = r; disp_tag = t;
    endtask

    task automatic chk_iss(input string req, input logic ev,
                           input logic [3:0] ei, input logic [15:0] ep);
        #1;
        total++;
        if (iss_valid !== ev || (ev && (iss_idx !== ei || iss_pay !== ep))) begin
            bad++;
            $display("FAIL %s issue actual v=%0b idx=%0d pay=%0h expected v=%0b idx=%0d pay=%0h",
                     req, iss_valid, iss_idx, iss_pay, ev, ei, ep);
        end
    endtask

    task automatic chk_cnt(input string req, input logic [3:0] ec, input logic ef);
        #1;
        total++;
        if (occupancy !== ec || full !== ef) begin
            bad++;
            $display("FAIL %s occupancy actual=%0d full=%0b expected=%0d full=%0b",
                     req, occupancy, full, ec, ef);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset();
        chk_cnt("R1", 4'd0, 1'b0);
        chk_iss("R1", 1'b0, 4'd0, 16'h0);

        // Table walk: R2 insertion, R3 select, R4 producer wakeup
        for (int k = 0; k < NV; k++) begin
            disp_valid = TBL[k].dv; disp_pay = TBL[k].dpay;
            disp_rdy = TBL[k].drdy; disp_tag = TBL[k].dtag;
            wk_valid = TBL[k].wv; wk_tag = TBL[k].wtag;
            chk_iss("R4", TBL[k].ev, TBL[k].eidx, TBL[k].epay);
            chk_cnt("R2", TBL[k].ecnt, 1'b0);
            tick();
        end

        // R6 miss blocks issue; R3 oldest first, issued entries stay
        do_reset();
        disp(16'h0B00, 1'b1, 5'd0); tick();
        disp(16'h0B01, 1'b1, 5'd0); miss_req = 1;
        chk_iss("R6", 1'b0, 4'd0, 16'h0); tick();
        miss_req = 1;
        chk_iss("R6", 1'b0, 4'd0, 16'h0); tick();
        chk_iss("R3", 1'b1, 4'd0, 16'h0B00); tick();
        chk_iss("R3", 1'b1, 4'd1, 16'h0B01); tick();
        chk_iss("R3", 1'b0, 4'd0, 16'h0);
        chk_cnt("R3", 4'd2, 1'b0); tick();

        // R5 dormant second half
        do_reset();
        disp(16'h0C00, 1'b1, 5'd0); disp_part2 = 1; disp_p2tag = 2'd2; tick();
        p2_valid = 1; p2_tag = 2'd1;
        chk_iss("R5", 1'b0, 4'd0, 16'h0); tick();
        p2_valid = 1; p2_tag = 2'd2;
        chk_iss("R5", 1'b0, 4'd0, 16'h0); tick();
        chk_iss("R5", 1'b1, 4'd0, 16'h0C00); tick();

        // R7 compaction, R8 dispatch during free
        do_reset();
        for (int k = 0; k < 4; k++) begin
            disp(16'h0E00 + 16'(k), 1'b0, 5'd20); tick();
        end
        free_valid = 1; free_idx = 4'd1; disp(16'h0E04, 1'b0, 5'd21);
        chk_cnt("R8", 4'd4, 1'b0); tick();
        free_valid = 1; free_idx = 4'd9;
        chk_cnt("R7", 4'd4, 1'b0); tick();
        wk_valid = 1; wk_tag = 5'd20;
        chk_cnt("R7", 4'd4, 1'b0); tick();
        chk_iss("R7", 1'b1, 4'd0, 16'h0E00); tick();
        chk_iss("R7", 1'b1, 4'd1, 16'h0E02); tick();
        chk_iss("R7", 1'b1, 4'd2, 16'h0E03); tick();
        wk_valid = 1; wk_tag = 5'd21;
        chk_iss("R8", 1'b0, 4'd0, 16'h0); tick();
        chk_iss("R8", 1'b1, 4'd3, 16'h0E04); tick();

        // R9 full flag and dropped dispatch
        do_reset();
        for (int k = 0; k < 12; k++) begin
            disp(16'h0100 + 16'(k), 1'b0, 5'd30); tick();
        end
        disp(16'h0BAD, 1'b1, 5'd0);
        chk_cnt("R9", 4'd12, 1'b1); tick();
        free_valid = 1; free_idx = 4'd0;
        chk_cnt("R9", 4'd12, 1'b1);
        chk_iss("R9", 1'b0, 4'd0, 16'h0); tick();
        wk_valid = 1; wk_tag = 5'd30;
        chk_cnt("R9", 4'd11, 1'b0); tick();
        for (int k = 0; k < 11; k++) begin
            chk_iss("R9", 1'b1, 4'(k), 16'h0101 + 16'(k)); tick();
        end
        chk_iss("R9", 1'b0, 4'd0, 16'h0); tick();

        // R10 flush keeps the oldest entries
        do_reset();
        for (int k = 0; k < 5; k++) begin
            disp(16'h0F00 + 16'(k), 1'b0, 5'd10); tick();
        end
        flush_valid = 1; flush_keep = 4'd2;
        disp(16'h0F05, 1'b1, 5'd0); free_valid = 1; free_idx = 4'd0; tick();
        wk_valid = 1; wk_tag = 5'd10;
        chk_cnt("R10", 4'd2, 1'b0); tick();
        chk_iss("R10", 1'b1, 4'd0, 16'h0F00); tick();
        chk_iss("R10", 1'b1, 4'd1, 16'h0F01); tick();
        chk_iss("R10", 1'b0, 4'd0, 16'h0);
        flush_valid = 1; flush_keep = 4'd7; tick();
        chk_cnt("R10", 4'd2, 1'b0); tick();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule